// File: doc/BRIEF.md
# eMMC Boot-Mode Receive Sequencer

This block is the host-side sequencer for the alternative boot read of an eMMC device. A boot command pulls the CMD line low and holds it there for the whole boot. In acknowledge mode the sequencer first waits for the card's acknowledge frame on DAT0 and checks it. It then waits for the start bit of the first data block and unpacks each block of single-line data into a byte stream. The boot ends when the programmed number of bytes has arrived, or earlier on an error, a timeout or a disable strobe. At every ending the sequencer releases CMD and then reports completion.

All DAT0 sampling happens on a one-cycle `bitEn` strobe, which marks each rising edge of the card clock. The acknowledge and data-start windows are counted with a 1 ms `msTick` pulse. Every window length, the block size and the size unit are parameters, so a simulation can run with short values. Results go to a vector of sticky status flags that software clears with write-one-to-clear.

Top module: `emmc_boot_rx`

## Requirements
- R1: After reset `cmdOut` is 1, `status` is all zero and `dataValid` is 0.
- R2: A boot starts only when `startCmd` and `bootEn` are both high while the block is idle, and `cmdOut` goes to 0 on that edge. `startCmd` without `bootEn` is ignored.
- R3: With `expectAck` high at start, the sequencer waits for a 0 start bit, takes three bits and then an end bit. The three bits must be 0,1,0 in arrival order and the end bit must be 1. When both hold, `status[1]` (acknowledge received) is set, `cmdOut` stays 0 and the sequencer waits for data.
- R4: If the three acknowledge bits are not 0,1,0, the boot aborts with no error flag and `status[1]` stays clear. If the acknowledge end bit is 0, the boot aborts and sets `status[5]` (end-bit error).
- R5: In acknowledge mode, if no acknowledge start bit arrives within ACK_MS ticks of the start, the boot ends and sets `status[6]` (boot error). `status[3]` stays clear.
- R6: The data start bit must arrive within DS_ACK_MS ticks of the acknowledge in acknowledge mode, or within DS_NOACK_MS ticks of the start otherwise. If it does not, the boot ends and sets `status[6]`.
- R7: Each data block is a 0 start bit, then BLK_BYTES*8 bits sent MSB first, then an end bit of 1. Every completed byte appears on `dataByte` with a one-cycle `dataValid` pulse. The first data start bit sets `status[2]` (data start).
- R8: The total length is `bootMult`*UNIT_BYTES bytes. After the end bit of the block that reaches this total, `status[3]` (transfer over) is set and CMD is released.
- R9: A data block end bit of 0 sets `status[5]` and aborts the boot.
- R10: Between blocks, NAC_BITS consecutive high samples with no start bit set `status[4]` (read timeout) and abort the boot.
- R11: Every ending drives `cmdOut` to 1 first. `status[0]` (command done) is set on the next clock and never earlier.
- R12: A `bootDis` pulse during a boot ends it with only `status[0]` raised.
- R13: Status flags stay set until a 1 is written to the matching bit of `statusClr`. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startCmd | input | 1 | Command start strobe |
| bootEn | input | 1 | Boot enable qualifier for startCmd |
| bootDis | input | 1 | Disable-boot strobe |
| expectAck | input | 1 | Acknowledge frame expected, latched at start |
| bootMult | input | MULT_W | Boot size multiplier in units of UNIT_BYTES |
| msTick | input | 1 | 1 ms timebase pulse |
| bitEn | input | 1 | Card clock rising-edge sample strobe |
| dat0 | input | 1 | DAT0 line from the card |
| statusClr | input | 7 | Write-one-to-clear mask for status |
| cmdOut | output | 1 | CMD line level driven to the card |
| dataValid | output | 1 | One-cycle byte valid pulse |
| dataByte | output | 8 | Received byte |
| status | output | 7 | Sticky flags: 0 done, 1 ack, 2 data start, 3 transfer over, 4 read timeout, 5 end-bit error, 6 boot error |

## Verification
Successful boots are run with and without acknowledge and with one and two size units. Their byte streams use values that differ in the MSB and the LSB, so a bit-order or packing fault changes the bytes the bench expects. Separate runs send an acknowledge with a wrong pattern and one with a wrong end bit, which tells the silent abort apart from the end-bit error. The timeout runs stop one tick or one sample short of each limit, and then step exactly to it, to pin down each window. The data-end-bit error, the between-block gap timeout and the disable strobe each need their own flag pattern at the release. The bench also checks at every ending that command done appears one cycle after CMD goes high.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK_WAIT,
    ST_ACK_BITS,
    ST_ACK_END,
    ST_DS_WAIT,
    ST_DATA,
    ST_DEND,
    ST_GAP,
    ST_RELEASE
  } bootState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAll;
    logic clrBlk;
    logic shiftEn;
    logic setDone;
    logic setAck;
    logic setDataStart;
    logic setDto;
    logic setDrto;
    logic setEbe;
    logic setErr;
  } ctrlStb_t;

  localparam int FLAG_N       = 7;
  localparam int F_DONE       = 0;
  localparam int F_ACK        = 1;
  localparam int F_DSTART     = 2;
  localparam int F_DTO        = 3;
  localparam int F_DRTO       = 4;
  localparam int F_EBE        = 5;
  localparam int F_ERR        = 6;

endpackage

// File: rtl/emmc_boot_ctrl.sv
module emmc_boot_ctrl
  import emmc_boot_pkg::*;
#(
  parameter int ACK_MS      = 50,
  parameter int DS_ACK_MS   = 950,
  parameter int DS_NOACK_MS = 1000,
  parameter int NAC_BITS    = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startCmd,
  input  logic     bootEn,
  input  logic     bootDis,
  input  logic     expectAck,
  input  logic     msTick,
  input  logic     bitEn,
  input  logic     dat0,
  input  logic     ackOk,
  input  logic     lastBit,
  input  logic     allDone,
  output logic     cmdOut,
  output ctrlStb_t stb
);

  localparam int MS_MAX0 = (ACK_MS > DS_ACK_MS) ? ACK_MS : DS_ACK_MS;
  localparam int MS_MAX  = (MS_MAX0 > DS_NOACK_MS) ? MS_MAX0 : DS_NOACK_MS;
  localparam int MS_W    = $clog2(MS_MAX + 1);
  localparam int NAC_W   = $clog2(NAC_BITS + 1);

  bootState_t       state, nextState;
  logic             ackMode;
  logic [MS_W-1:0]  msCnt;
  logic [NAC_W-1:0] nacCnt;
  logic [1:0]       ackCnt;
  logic [MS_W-1:0]  dsLimit;
  logic             active;

  assign dsLimit = ackMode ? MS_W'(DS_ACK_MS - 1) : MS_W'(DS_NOACK_MS - 1);
  assign active  = (state != ST_IDLE) && (state != ST_RELEASE);

  always_comb begin
    stb       = '0;
    nextState = state;
    if (bootDis && active) begin
      nextState = ST_RELEASE;
    end else begin
      case (state)
        ST_IDLE: if (startCmd && bootEn) begin
          stb.clrAll = 1'b1;
          nextState  = expectAck ? ST_ACK_WAIT : ST_DS_WAIT;
        end
        ST_ACK_WAIT: begin
          if (bitEn && !dat0) nextState = ST_ACK_BITS;
          else if (msTick && msCnt == MS_W'(ACK_MS - 1)) begin
            stb.setErr = 1'b1;
            nextState  = ST_RELEASE;
          end
        end
        ST_ACK_BITS: if (bitEn) begin
          stb.shiftEn = 1'b1;
          if (ackCnt == 2'd2) nextState = ST_ACK_END;
        end
        ST_ACK_END: if (bitEn) begin
          if (!dat0) begin
            stb.setEbe = 1'b1;
            nextState  = ST_RELEASE;
          end else if (ackOk) begin
            stb.setAck = 1'b1;
            nextState  = ST_DS_WAIT;
          end else begin
            nextState  = ST_RELEASE;
          end
        end
        ST_DS_WAIT: begin
          if (bitEn && !dat0) begin
            stb.setDataStart = 1'b1;
            stb.clrBlk       = 1'b1;
            nextState        = ST_DATA;
          end else if (msTick && msCnt == dsLimit) begin
            stb.setErr = 1'b1;
            nextState  = ST_RELEASE;
          end
        end
        ST_DATA: if (bitEn) begin
          stb.shiftEn = 1'b1;
          if (lastBit) nextState = ST_DEND;
        end
        ST_DEND: if (bitEn) begin
          if (!dat0) begin
            stb.setEbe = 1'b1;
            nextState  = ST_RELEASE;
          end else if (allDone) begin
            stb.setDto = 1'b1;
            nextState  = ST_RELEASE;
          end else begin
            nextState  = ST_GAP;
          end
        end
        ST_GAP: if (bitEn) begin
          if (!dat0) begin
            stb.clrBlk = 1'b1;
            nextState  = ST_DATA;
          end else if (nacCnt == NAC_W'(NAC_BITS - 1)) begin
            stb.setDrto = 1'b1;
            nextState   = ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          stb.setDone = 1'b1;
          nextState   = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdOut  <= 1'b1;
      ackMode <= 1'b0;
      msCnt   <= '0;
      nacCnt  <= '0;
      ackCnt  <= '0;
    end else begin
      state  <= nextState;
      cmdOut <= (nextState == ST_IDLE) || (nextState == ST_RELEASE);
      if (stb.clrAll) ackMode <= expectAck;
      if (nextState != state) msCnt <= '0;
      else if (msTick)        msCnt <= msCnt + 1'b1;
      if (state != ST_GAP)    nacCnt <= '0;
      else if (bitEn)         nacCnt <= nacCnt + 1'b1;
      if (state != ST_ACK_BITS) ackCnt <= '0;
      else if (bitEn)           ackCnt <= ackCnt + 1'b1;
    end
  end

  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_WAIT) |-> (msCnt < MS_W'(ACK_MS))); // R5

  AST_GAP_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> (nacCnt < NAC_W'(NAC_BITS))); // R10

endmodule

// File: rtl/emmc_boot_datapath.sv
module emmc_boot_datapath
  import emmc_boot_pkg::*;
#(
  parameter int BLK_BYTES  = 512,
  parameter int UNIT_BYTES = 131072,
  parameter int MULT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              dat0,
  input  logic [MULT_W-1:0] bootMult,
  input  logic [FLAG_N-1:0] statusClr,
  output logic              ackOk,
  output logic              lastBit,
  output logic              allDone,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic [FLAG_N-1:0] status
);

  localparam int BLK_BITS = BLK_BYTES * 8;
  localparam int BIT_W    = $clog2(BLK_BITS + 1);
  localparam int TOT_W    = MULT_W + $clog2(UNIT_BYTES + 1);

  logic [6:0]        sh;
  logic [BIT_W-1:0]  bitIdx;
  logic [TOT_W-1:0]  byteCnt;
  logic [TOT_W-1:0]  totalBytes;
  logic [FLAG_N-1:0] setVec;

  assign totalBytes = TOT_W'(bootMult) * TOT_W'(UNIT_BYTES);
  assign ackOk      = (sh[2:0] == 3'b010);
  assign lastBit    = (bitIdx == BIT_W'(BLK_BITS - 1));
  assign allDone    = (byteCnt >= totalBytes);

  always_comb begin
    setVec           = '0;
    setVec[F_DONE]   = stb.setDone;
    setVec[F_ACK]    = stb.setAck;
    setVec[F_DSTART] = stb.setDataStart;
    setVec[F_DTO]    = stb.setDto;
    setVec[F_DRTO]   = stb.setDrto;
    setVec[F_EBE]    = stb.setEbe;
    setVec[F_ERR]    = stb.setErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh        <= '0;
      bitIdx    <= '0;
      byteCnt   <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      status    <= '0;
    end else begin
      status    <= (status & ~statusClr) | setVec;
      dataValid <= 1'b0;
      if (stb.clrAll) begin
        bitIdx  <= '0;
        byteCnt <= '0;
      end else if (stb.clrBlk) begin
        bitIdx  <= '0;
      end else if (stb.shiftEn) begin
        sh     <= {sh[5:0], dat0};
        bitIdx <= bitIdx + 1'b1;
        if (bitIdx[2:0] == 3'd7) begin
          dataValid <= 1'b1;
          dataByte  <= {sh, dat0};
          byteCnt   <= byteCnt + 1'b1;
        end
      end
    end
  end

  AST_NO_EXTRA_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && totalBytes != '0) |-> (byteCnt <= totalBytes)); // R8

endmodule

// File: rtl/emmc_boot_rx.sv
module emmc_boot_rx
  import emmc_boot_pkg::*;
#(
  parameter int ACK_MS      = 50,
  parameter int DS_ACK_MS   = 950,
  parameter int DS_NOACK_MS = 1000,
  parameter int NAC_BITS    = 1024,
  parameter int BLK_BYTES   = 512,
  parameter int UNIT_BYTES  = 131072,
  parameter int MULT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              bootEn,
  input  logic              bootDis,
  input  logic              expectAck,
  input  logic [MULT_W-1:0] bootMult,
  input  logic              msTick,
  input  logic              bitEn,
  input  logic              dat0,
  input  logic [6:0]        statusClr,
  output logic              cmdOut,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic [6:0]        status
);

  ctrlStb_t stb;
  logic     ackOk, lastBit, allDone;

  emmc_boot_ctrl #(
    .ACK_MS(ACK_MS), .DS_ACK_MS(DS_ACK_MS),
    .DS_NOACK_MS(DS_NOACK_MS), .NAC_BITS(NAC_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .bootEn(bootEn),
    .bootDis(bootDis), .expectAck(expectAck), .msTick(msTick),
    .bitEn(bitEn), .dat0(dat0), .ackOk(ackOk), .lastBit(lastBit),
    .allDone(allDone), .cmdOut(cmdOut), .stb(stb)
  );

  emmc_boot_datapath #(
    .BLK_BYTES(BLK_BYTES), .UNIT_BYTES(UNIT_BYTES), .MULT_W(MULT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .dat0(dat0), .bootMult(bootMult),
    .statusClr(statusClr), .ackOk(ackOk), .lastBit(lastBit),
    .allDone(allDone), .dataValid(dataValid), .dataByte(dataByte),
    .status(status)
  );

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[F_DONE]) |-> (cmdOut && $past(cmdOut))); // R11

  AST_BYTES_UNDER_CMD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !cmdOut); // R7

  AST_TIMEOUT_NOT_SUCCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[F_ERR]) |-> !$rose(status[F_DTO])); // R5

endmodule

// File: tb/sim_emmc_boot_rx.sv
module sim_emmc_boot_rx;

  localparam int ACK_MS = 5, DS_ACK_MS = 8, DS_NOACK_MS = 10, NAC_BITS = 6;
  localparam int BLK_BYTES = 2, UNIT_BYTES = 4, MULT_W = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic startCmd = 0, bootEn = 0, bootDis = 0, expectAck = 0;
  logic [MULT_W-1:0] bootMult = '0;
  logic msTick = 0, bitEn = 0, dat0 = 1;
  logic [6:0] statusClr = '0;
  logic cmdOut, dataValid;
  logic [7:0] dataByte;
  logic [6:0] status;

  emmc_boot_rx #(
    .ACK_MS(ACK_MS), .DS_ACK_MS(DS_ACK_MS), .DS_NOACK_MS(DS_NOACK_MS),
    .NAC_BITS(NAC_BITS), .BLK_BYTES(BLK_BYTES), .UNIT_BYTES(UNIT_BYTES),
    .MULT_W(MULT_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .bootEn(bootEn),
    .bootDis(bootDis), .expectAck(expectAck), .bootMult(bootMult),
    .msTick(msTick), .bitEn(bitEn), .dat0(dat0), .statusClr(statusClr),
    .cmdOut(cmdOut), .dataValid(dataValid), .dataByte(dataByte),
    .status(status)
  );

  always #4 clk = ~clk;

  integer compared = 0, mismatched = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte stream reference: every received byte compared on the clock it appears
  always @(negedge clk) begin : cmpBytes
    logic [7:0] e;
    if (rstN && dataValid) begin
      if (expQ.size() == 0) chk(1'b0, "R7 unexpected byte", dataByte, 0);
      else begin
        e = expQ.pop_front();
        chk(dataByte == e, "R7 byte value", dataByte, e);
      end
    end
  end

  task automatic bitOut(input logic b);
    @(negedge clk); dat0 = b; bitEn = 1;
    @(negedge clk); bitEn = 0; dat0 = 1;
  endtask

  task automatic tick();
    @(negedge clk); msTick = 1;
    @(negedge clk); msTick = 0;
  endtask

  task automatic startBoot(input logic ack, input int mult);
    @(negedge clk); startCmd = 1; bootEn = 1; expectAck = ack; bootMult = MULT_W'(mult);
    @(negedge clk); startCmd = 0; bootEn = 0;
    chk(cmdOut == 0, "R2 CMD driven low", cmdOut, 0);
  endtask

  task automatic sendByte(input logic [7:0] v);
    expQ.push_back(v);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
  endtask

  task automatic sendBlock(input logic [7:0] a, input logic [7:0] b, input logic endBit);
    bitOut(0); sendByte(a); sendByte(b); bitOut(endBit);
  endtask

  task automatic ackFrame(input logic [2:0] pat, input logic endBit);
    bitOut(1); bitOut(0);
    bitOut(pat[2]); bitOut(pat[1]); bitOut(pat[0]);
    bitOut(endBit);
  endtask

  task automatic clearAll();
    @(negedge clk); statusClr = 7'h7F;
    @(negedge clk); statusClr = '0;
  endtask

  // called right after the edge that ends a boot
  task automatic endCheck(input string req, input logic [6:0] expStat);
    chk(cmdOut == 1, {req, " CMD released"}, cmdOut, 1);
    chk(status[0] == 0, "R11 done not before release", status[0], 0);
    @(negedge clk);
    chk(status == expStat, {req, " status"}, status, expStat);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmdOut == 1, "R1 reset cmdOut", cmdOut, 1);
    chk(status == 0, "R1 reset status", status, 0);
    chk(dataValid == 0, "R1 reset dataValid", dataValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2: start without boot enable is ignored
    @(negedge clk); startCmd = 1; bootEn = 0;
    @(negedge clk); startCmd = 0;
    repeat (2) @(negedge clk);
    chk(cmdOut == 1 && status == 0, "R2 start without enable ignored", {cmdOut, status}, 8'h80);

    // R7 R8: no-ack boot, one unit = two blocks
    startBoot(0, 1);
    bitOut(1); bitOut(1);
    sendBlock(8'hA5, 8'h3C, 1);
    chk(status[2] == 1 && cmdOut == 0, "R7 data start flag", status, 7'h04);
    bitOut(1);
    sendBlock(8'h0F, 8'h81, 1);
    chk(status[3] == 1, "R8 transfer over", status, 7'h08);
    chk(cmdOut == 1 && status[0] == 0, "R11 release precedes done", {cmdOut, status[0]}, 2'b10);
    @(negedge clk);
    chk(status == 7'h0D, "R8 success status", status, 7'h0D);
    // R13: partial clear of transfer-over only
    @(negedge clk); statusClr = 7'h08;
    @(negedge clk); statusClr = '0;
    chk(status == 7'h05, "R13 write-one-to-clear", status, 7'h05);
    repeat (2) @(negedge clk);
    chk(status == 7'h05, "R13 flags sticky", status, 7'h05);
    clearAll();

    // R3 R8: ack boot, two units = four blocks
    startBoot(1, 2);
    ackFrame(3'b010, 1);
    chk(status[1] == 1 && cmdOut == 0, "R3 ack received", status, 7'h02);
    bitOut(1);
    sendBlock(8'h80, 8'h01, 1);
    sendBlock(8'hFE, 8'h7F, 1);
    bitOut(1); bitOut(1);
    sendBlock(8'h55, 8'hAA, 1);
    chk(cmdOut == 0, "R8 not done before total", cmdOut, 0);
    sendBlock(8'hC3, 8'h18, 1);
    endCheck("R8 two-unit boot", 7'h0F);

    // R4: wrong ack pattern aborts quietly
    startBoot(1, 1);
    ackFrame(3'b011, 1);
    endCheck("R4 bad ack pattern", 7'h01);

    // R4: ack end bit error
    startBoot(1, 1);
    ackFrame(3'b010, 0);
    endCheck("R4 ack end bit", 7'h21);

    // R5: ack timeout boundary
    startBoot(1, 1);
    repeat (ACK_MS - 1) tick();
    chk(cmdOut == 0, "R5 still waiting one tick short", cmdOut, 0);
    tick();
    endCheck("R5 ack timeout", 7'h41);

    // R6: data start timeout after ack
    startBoot(1, 1);
    repeat (3) tick();
    ackFrame(3'b010, 1);
    repeat (DS_ACK_MS - 1) tick();
    chk(cmdOut == 0, "R6 ack-mode window one short", cmdOut, 0);
    tick();
    endCheck("R6 data start timeout after ack", 7'h43);

    // R6: data start timeout without ack
    startBoot(0, 1);
    repeat (DS_NOACK_MS - 1) tick();
    chk(cmdOut == 0, "R6 no-ack window one short", cmdOut, 0);
    tick();
    endCheck("R6 data start timeout no ack", 7'h41);

    // R9: data end bit error
    startBoot(0, 1);
    sendBlock(8'h12, 8'h34, 0);
    endCheck("R9 data end bit", 7'h25);

    // R10: gap timeout between blocks
    startBoot(0, 1);
    sendBlock(8'h9C, 8'h63, 1);
    repeat (NAC_BITS - 1) bitOut(1);
    chk(cmdOut == 0, "R10 gap one sample short", cmdOut, 0);
    bitOut(1);
    endCheck("R10 read timeout", 7'h15);

    // R12: disable strobe
    startBoot(0, 1);
    repeat (2) tick();
    @(negedge clk); bootDis = 1;
    @(negedge clk); bootDis = 0;
    endCheck("R12 disable boot", 7'h01);

    chk(expQ.size() == 0, "R7 all bytes delivered", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule